// File: doc/BRIEF.md
# Dual-Bank Interrupt Request Controller

This block gathers single-cycle event pulses from neighbouring logic and holds each one as a sticky request flag until firmware clears it. The flags live in two banks of seven. Each bank has a matching enable bank of seven bits. A single active-high interrupt line rises whenever any flag is pending while its enable bit is set, in either bank.

Firmware reaches the four registers through a plain address, write-data and write-strobe port, and reads them back combinationally. Every write uses its top bit as a direction selector. With bit 7 high, each 1 among bits 0 to 6 sets the matching bit. With bit 7 low, each such 1 clears the matching bit. A 0 in those positions leaves the bit alone, so single flags can be forced or acknowledged without a read-modify-write.

Hardware sources are wired to fixed positions. Bank 0 takes transmit-end, command-done, FIFO high-water and FIFO low-water. Bank 1 takes the four timer underflows. The remaining three positions of each bank are only reachable by firmware.

Top module: `irq_hub`

## Requirements
- R1: Synchronous reset clears all flags and all enable bits. The interrupt line is low afterwards, and all four addresses read 0x00.
- R2: A write with bit 7 = 1 to a flag register (address 0 = bank 0, address 1 = bank 1) sets each flag whose data bit among 0..6 is 1 and leaves the others unchanged.
- R3: A write with bit 7 = 0 to a flag register clears each flag whose data bit among 0..6 is 1 and leaves the others unchanged.
- R4: Enable registers (address 2 = bank 0, address 3 = bank 1) follow the same set/clear convention as R2 and R3.
- R5: Event pulses set bank 0 flags at these positions: transmit-end to bit 0, command-done to bit 1, FIFO high-water to bit 2, FIFO low-water to bit 3. The flag is visible after the clock edge that samples the pulse.
- R6: Each timer underflow pulse n (0..3) sets bank 1 flag bit n.
- R7: When an event pulse and a firmware clear target the same flag in the same cycle, the flag ends up set.
- R8: Reading a flag register returns the seven flags in bits 0..6. Bit 7 is the OR of that bank's enabled pending flags. Reading an enable register returns the enables in bits 0..6 and 0 in bit 7.
- R9: irqOut is high exactly when some flag and its enable are both set, in either bank. It reflects each register update in the cycle that follows the clock edge.
- R10: Flags are sticky. They are set whether or not they are enabled, and they hold until a firmware clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 2 | Register select for both read and write |
| regWrData | input | 8 | Write data; bit 7 selects set (1) or clear (0) |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 8 | Combinational read data for regAddr |
| timerUnder | input | 4 | Timer underflow pulses, one per timer |
| cmdDone | input | 1 | Command-finished pulse |
| txEnd | input | 1 | Transmission-ended pulse |
| fifoHigh | input | 1 | FIFO high-water pulse |
| fifoLow | input | 1 | FIFO low-water pulse |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The assertions watch, on every cycle, the following behaviours:
- an event pulse always leaves its flag set, which includes a clash with a clear;
- the flag-register read bit 7 implies the interrupt line;
- the line stays low with every enable off;
- firmware-only flags never change without a write;
- the set and clear writes land on the targeted bits.

Only the bench's scenarios can show the full bit-level effects of mixed masks:
- that zeros leave bits untouched;
- that enables in one bank do not leak into the other bank's bit 7;
- that reset midway through activity returns every register to zero.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NUM_BANKS = 2;
  localparam int FLAG_W    = 7;
  localparam int DATA_W    = FLAG_W + 1;
  localparam int ADDR_W    = $clog2(2 * NUM_BANKS);

  typedef logic [NUM_BANKS-1:0][FLAG_W-1:0] bankVec_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] reqWr;
    logic [NUM_BANKS-1:0] enWr;
    logic                 setMode;
    logic [FLAG_W-1:0]    bits;
  } wrStrobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output wrStrobe_t         strb
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign strb.reqWr[b] = regWrEn && (regAddr == ADDR_W'(b));
    assign strb.enWr[b]  = regWrEn && (regAddr == ADDR_W'(NUM_BANKS + b));
  end
  assign strb.setMode = regWrData[DATA_W-1];
  assign strb.bits    = regWrData[FLAG_W-1:0];
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strb,
  input  bankVec_t          hwSet,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output bankVec_t          flagQ,
  output bankVec_t          enQ,
  output logic              irqOut
);
  logic [NUM_BANKS-1:0] pending;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [FLAG_W-1:0] flagReg, flagNext, enReg, enNext;
    logic [FLAG_W-1:0] setMask, clrMask, enSet, enClr;

    always_comb begin
      setMask  = (strb.reqWr[b] &&  strb.setMode) ? strb.bits : '0;
      clrMask  = (strb.reqWr[b] && !strb.setMode) ? strb.bits : '0;
      enSet    = (strb.enWr[b]  &&  strb.setMode) ? strb.bits : '0;
      enClr    = (strb.enWr[b]  && !strb.setMode) ? strb.bits : '0;
      // hardware pulses are ORed last so they override a clear
      flagNext = (flagReg & ~clrMask) | setMask | hwSet[b];
      enNext   = (enReg & ~enClr) | enSet;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flagReg <= '0;
        enReg   <= '0;
      end else begin
        flagReg <= flagNext;
        enReg   <= enNext;
      end
    end

    assign flagQ[b]   = flagReg;
    assign enQ[b]     = enReg;
    assign pending[b] = |(flagReg & enReg);
  end

  assign irqOut = |pending;

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdAddr == ADDR_W'(b))             rdData = {pending[b], flagQ[b]};
      if (rdAddr == ADDR_W'(NUM_BANKS + b)) rdData = {1'b0, enQ[b]};
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic [3:0]        timerUnder,
  input  logic              cmdDone,
  input  logic              txEnd,
  input  logic              fifoHigh,
  input  logic              fifoLow,
  output logic              irqOut
);
  wrStrobe_t strb;
  bankVec_t  hwSet, flagQ, enQ;

  assign hwSet[0] = FLAG_W'({fifoLow, fifoHigh, cmdDone, txEnd});
  assign hwSet[1] = FLAG_W'(timerUnder);

  irq_hub_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb)
  );

  irq_hub_dp u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .hwSet (hwSet),
    .rdAddr(regAddr),
    .rdData(regRdData),
    .flagQ (flagQ),
    .enQ   (enQ),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regRdData,
  input logic [3:0]        timerUnder,
  input logic              txEnd,
  input logic              irqOut,
  input bankVec_t          flagQ,
  input bankVec_t          enQ
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irqOut); // R1
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd1 && regWrData[7] && regWrData[5]) |=> flagQ[1][5]); // R2
  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd0 && !regWrData[7] && regWrData[4]) |=> !flagQ[0][4]); // R3
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd2 && regWrData[7] && regWrData[0]) |=> enQ[0][0]); // R4
  AST_TXEND_FLAG: assert property (@(posedge clk) disable iff (rst)
    txEnd |=> flagQ[0][0]); // R7
  AST_TIMER_FLAG: assert property (@(posedge clk) disable iff (rst)
    timerUnder[3] |=> flagQ[1][3]); // R6
  AST_READ_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (regAddr < 2'd2 && regRdData[7]) |-> irqOut); // R8
  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (enQ == '0) |-> !irqOut); // R9
  AST_SOFT_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !regWrEn |=> $stable(flagQ[0][6:4])); // R10
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .timerUnder(timerUnder),
  .txEnd     (txEnd),
  .irqOut    (irqOut),
  .flagQ     (flagQ),
  .enQ       (enQ)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic       regWrEn;
  logic [7:0] regRdData;
  logic [3:0] timerUnder;
  logic       cmdDone, txEnd, fifoHigh, fifoLow;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .timerUnder(timerUnder),
    .cmdDone(cmdDone), .txEnd(txEnd), .fifoHigh(fifoHigh), .fifoLow(fifoLow),
    .irqOut(irqOut)
  );

  // ev bits: [3:0] timers, [4] txEnd, [5] cmdDone, [6] fifoHigh, [7] fifoLow
  typedef struct packed {
    logic       we;
    logic [1:0] wa;
    logic [7:0] wd;
    logic [7:0] ev;
    logic [1:0] ra;
    logic [7:0] er;
    logic       ei;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 8'h90, 8'h00, 2'd0, 8'h10, 1'b0, 4'd2},  // R2 set bank0 bit4
    '{1'b1, 2'd2, 8'h90, 8'h00, 2'd0, 8'h90, 1'b1, 4'd4},  // R4 enable bit4
    '{1'b0, 2'd0, 8'h00, 8'h00, 2'd2, 8'h10, 1'b1, 4'd8},  // R8 enable read bit7=0
    '{1'b1, 2'd0, 8'h10, 8'h00, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 clear bit4
    '{1'b0, 2'd0, 8'h00, 8'h10, 2'd0, 8'h01, 1'b0, 4'd5},  // R5 txEnd
    '{1'b0, 2'd0, 8'h00, 8'hE0, 2'd0, 8'h0F, 1'b0, 4'd5},  // R5 cmd/high/low
    '{1'b1, 2'd0, 8'h06, 8'h00, 2'd0, 8'h09, 1'b0, 4'd3},  // R3 partial clear
    '{1'b0, 2'd0, 8'h00, 8'h05, 2'd1, 8'h05, 1'b0, 4'd6},  // R6 timers 0,2
    '{1'b1, 2'd3, 8'h84, 8'h00, 2'd1, 8'h85, 1'b1, 4'd9},  // R9 enable timer2
    '{1'b0, 2'd0, 8'h00, 8'h00, 2'd0, 8'h09, 1'b1, 4'd8},  // R8 per-bank bit7
    '{1'b1, 2'd1, 8'h05, 8'h01, 2'd1, 8'h01, 1'b0, 4'd7},  // R7 clash, hw wins
    '{1'b1, 2'd3, 8'h81, 8'h00, 2'd1, 8'h81, 1'b1, 4'd9},  // R9 enable timer0
    '{1'b1, 2'd3, 8'h05, 8'h00, 2'd3, 8'h00, 1'b0, 4'd4},  // R4 clear enables
    '{1'b1, 2'd0, 8'h80, 8'h00, 2'd0, 8'h09, 1'b0, 4'd2},  // R2 empty set mask
    '{1'b1, 2'd0, 8'h7F, 8'h00, 2'd0, 8'h00, 1'b0, 4'd3}   // R3 clear all
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic idleIn();
    regWrEn = 1'b0; regWrData = '0; timerUnder = '0;
    cmdDone = 1'b0; txEnd = 1'b0; fifoHigh = 1'b0; fifoLow = 1'b0;
  endtask

  task automatic step(input logic we, input logic [1:0] wa, input logic [7:0] wd,
                      input logic [7:0] ev);
    @(negedge clk);
    regWrEn = we; regAddr = wa; regWrData = wd;
    timerUnder = ev[3:0]; txEnd = ev[4]; cmdDone = ev[5];
    fifoHigh = ev[6]; fifoLow = ev[7];
    @(negedge clk);
    idleIn();
  endtask

  task automatic readAt(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; regAddr = '0; idleIn();
    doReset();
    // R1: reset state on every address
    for (int a = 0; a < 4; a++) begin
      readAt(2'(a), d);
      check("R1 reset read", d, 8'h00);
    end
    check("R1 reset irq", {7'd0, irqOut}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ev);
      readAt(VECS[i].ra, d);
      check($sformatf("R%0d vec %0d read", VECS[i].req, i), d, VECS[i].er);
      check($sformatf("R%0d vec %0d irq", VECS[i].req, i), {7'd0, irqOut}, {7'd0, VECS[i].ei});
    end

    // R10: sticky flag without enable, held over idle cycles
    step(1'b0, 2'd0, 8'h00, 8'h20);
    repeat (5) @(negedge clk);
    readAt(2'd0, d);
    check("R10 sticky flag", d, 8'h02);
    check("R10 no irq when disabled", {7'd0, irqOut}, 8'h00);

    // R9: enabling after the fact raises the line, clearing drops it
    step(1'b1, 2'd2, 8'h82, 8'h00);
    check("R9 irq after enable", {7'd0, irqOut}, 8'h01);
    step(1'b1, 2'd0, 8'h02, 8'h00);
    check("R9 irq after clear", {7'd0, irqOut}, 8'h00);

    // R1: reset in the middle of activity
    step(1'b1, 2'd1, 8'hFF, 8'h00);
    step(1'b1, 2'd3, 8'hFF, 8'h00);
    check("R1 irq before reset", {7'd0, irqOut}, 8'h01);
    doReset();
    for (int a = 0; a < 4; a++) begin
      readAt(2'(a), d);
      check("R1 read after mid reset", d, 8'h00);
    end
    check("R1 irq after mid reset", {7'd0, irqOut}, 8'h00);

    finishRun();
  end
endmodule